// File: doc/BRIEF.md
# Cache Tag and Valid RAM Self-Test Sequencer

This block is a built-in self-test controller for the tag store of an eight-way set-associative cache. It drives the tag RAM one pair of ways at a time. It drives the 16-bit valid RAM only while the first pair is under test. Each pair is swept with a short march over the tag index range. Read data are compared with the expected background one cycle after each read is issued. The first miscompare freezes a structured failure address and a flag that tells which half of the compare word failed.

The tag RAM returns two ways per read. The lower-numbered way sits in bits [22:0] and the higher-numbered way sits in bits [45:23]. The compare word is 65 bits wide and is laid out as {3'b000, valid_rdata[15:0], tag_rdata[45:0]}. The index is `IDX_W` bits wide and sits inside an 11-bit RAM address. Address bits above the index are not swept: they are taken from the `scramble` input. A run starts with a pulse on `start`, ends with a one-cycle pulse on `done`, and leaves the verdict on `fail`, `fail_addr` and `fail_half` until the next run starts.

Top module: `tagval_bist`

## Requirements
- R1: A run tests the way pairs in four steps, in this order: `tag_grp` = 0 (ways 1 and 0), 1 (ways 3 and 2), 2 (ways 5 and 4), 3 (ways 7 and 6). `tag_grp` never decreases within a run.
- R2: In both `tag_wdata` and `tag_rdata`, bits [22:0] carry way 2*`tag_grp` and bits [45:23] carry way 2*`tag_grp`+1.
- R3: `val_cs` is asserted only during step 0. In that step every tag access also accesses the valid RAM, so a run makes exactly 4·2^IDX_W valid accesses and compares all 16 valid bits.
- R4: `fail_addr` = {tag_grp[1:0], 4'b0000, address[10:0]}. Bits [14:11] are always zero.
- R5: `tag_addr` and `val_addr` bits [10:IDX_W] equal `scramble` bits [10:IDX_W]. Bits [IDX_W-1:0] carry the swept index.
- R6: `fail_half` is 0 if the first failing compare has any mismatch in compare-word bits [31:0]. Otherwise it is 1.
- R7: Each step runs a march with three elements. First, write the background in ascending order. Second, in ascending order, read the background and then write its inverse, one cycle each. Third, read the inverse in descending order. A run therefore makes 16·2^IDX_W tag accesses. A stuck-at-0 or stuck-at-1 bit is detected.
- R8: Only the first miscompare sets `fail_addr` and `fail_half`. `fail` is sticky until the next run starts.
- R9: `done` pulses for exactly one cycle, 16·2^IDX_W+1 clock edges after the edge that accepts `start`. The block then returns to idle (`busy` low). A `start` pulse during a run has no effect.
- R10: Read data are compared one cycle after the read is issued, against the index and group of that read.
- R11: After reset, `busy`, `done`, `fail`, `fail_half`, `tag_cs` and `val_cs` are 0 and `fail_addr` is 0.
- R12: Starting a new run clears `fail`, `fail_addr` and `fail_half` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| scramble | input | 11 | Fixed values for address bits above the index |
| tag_rdata | input | 46 | Tag read data for the current way pair |
| val_rdata | input | 16 | Valid RAM read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky miscompare flag |
| fail_addr | output | 17 | Captured failure address |
| fail_half | output | 1 | Half of the compare word holding the first failure |
| tag_cs | output | 1 | Tag RAM chip select |
| tag_we | output | 1 | Tag RAM write enable |
| tag_grp | output | 2 | Way-pair select |
| tag_addr | output | 11 | Tag RAM address |
| tag_wdata | output | 46 | Tag write data for the way pair |
| val_cs | output | 1 | Valid RAM chip select |
| val_we | output | 1 | Valid RAM write enable |
| val_addr | output | 11 | Valid RAM address |
| val_wdata | output | 16 | Valid RAM write data |

## Verification
The bench builds the block with IDX_W = 3. A full four-step run then lasts only 129 cycles, so every stuck bit, way, half boundary (compare bits 31 and 32) and scramble pattern in the table can each get a complete run. With eight address bits taken from `scramble`, any address bit that leaks from the index counter becomes visible. The default alternating backgrounds mean that stuck-at-1 and stuck-at-0 faults are caught in different march elements.

// File: rtl/tagval_bist_pkg.sv
package tagval_bist_pkg;

    localparam int WAY_TAG_W  = 23;
    localparam int PAIR_W     = 2 * WAY_TAG_W;
    localparam int VAL_W      = 16;
    localparam int FULL_IDX_W = 11;
    localparam int GRP_W      = 2;
    localparam int GAP_W      = 4;
    localparam int FA_W       = GRP_W + GAP_W + FULL_IDX_W;
    localparam int CMP_W      = 65;
    localparam int CMP_PAD    = CMP_W - PAIR_W - VAL_W;
    localparam int HALF_SPLIT = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_BG,
        PH_RD_BG,
        PH_WR_INV,
        PH_RD_INV,
        PH_FLUSH,
        PH_DONE
    } phase_e;

    function automatic logic [FA_W-1:0] pack_fail_addr(
        input logic [GRP_W-1:0]      grp,
        input logic [FULL_IDX_W-1:0] addr
    );
        return {grp, {GAP_W{1'b0}}, addr};
    endfunction

endpackage

// File: rtl/tagval_seq.sv
module tagval_seq
    import tagval_bist_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [GRP_W-1:0] step,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done,
    output logic             clear,
    output logic             req,
    output logic             we,
    output logic             inv
);

    localparam logic [IDX_W-1:0] IDX_LAST  = '1;
    localparam logic [GRP_W-1:0] STEP_LAST = '1;

    typedef struct packed {
        phase_e           phase;
        logic [GRP_W-1:0] step;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase = PH_WR_BG;
                    seq_d.step  = '0;
                    seq_d.idx   = '0;
                end
            end
            PH_WR_BG: begin
                if (seq_q.idx == IDX_LAST) begin
                    seq_d.phase = PH_RD_BG;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            PH_RD_BG: begin
                seq_d.phase = PH_WR_INV;
            end
            PH_WR_INV: begin
                if (seq_q.idx == IDX_LAST) begin
                    seq_d.phase = PH_RD_INV;
                end else begin
                    seq_d.idx   = seq_q.idx + 1'b1;
                    seq_d.phase = PH_RD_BG;
                end
            end
            PH_RD_INV: begin
                if (seq_q.idx == '0) begin
                    if (seq_q.step == STEP_LAST) begin
                        seq_d.phase = PH_FLUSH;
                    end else begin
                        seq_d.step  = seq_q.step + 1'b1;
                        seq_d.phase = PH_WR_BG;
                    end
                end else begin
                    seq_d.idx = seq_q.idx - 1'b1;
                end
            end
            PH_FLUSH: seq_d.phase = PH_DONE;
            PH_DONE:  seq_d.phase = PH_IDLE;
            default:  seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, step: '0, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step  = seq_q.step;
    assign idx   = seq_q.idx;
    assign busy  = (seq_q.phase != PH_IDLE);
    assign done  = (seq_q.phase == PH_DONE);
    assign clear = (seq_q.phase == PH_IDLE) && start;
    assign req   = (seq_q.phase == PH_WR_BG) || (seq_q.phase == PH_RD_BG) ||
                   (seq_q.phase == PH_WR_INV) || (seq_q.phase == PH_RD_INV);
    assign we    = (seq_q.phase == PH_WR_BG) || (seq_q.phase == PH_WR_INV);
    assign inv   = (seq_q.phase == PH_WR_INV) || (seq_q.phase == PH_RD_INV);

    // R9: the end-of-run strobe never lasts two cycles
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: each ascending read is followed by the inverse write at the same index
    a_r7_read_then_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RD_BG) |=> ((seq_q.phase == PH_WR_INV) && $stable(seq_q.idx)));

endmodule

// File: rtl/tagval_addr.sv
module tagval_addr
    import tagval_bist_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]      idx,
    input  logic [FULL_IDX_W-1:0] scramble,
    output logic [FULL_IDX_W-1:0] addr
);

    localparam logic [FULL_IDX_W-1:0] SWEEP_MASK = FULL_IDX_W'((1 << IDX_W) - 1);

    always_comb begin
        addr = (scramble & ~SWEEP_MASK) | (FULL_IDX_W'(idx) & SWEEP_MASK);
    end

endmodule

// File: rtl/tagval_cmp.sv
module tagval_cmp
    import tagval_bist_pkg::*;
#(
    parameter logic [PAIR_W-1:0] BG_TAG = {PAIR_W/2{2'b01}},
    parameter logic [VAL_W-1:0]  BG_VAL = {VAL_W/2{2'b01}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  issue_rd,
    input  logic                  issue_inv,
    input  logic [FULL_IDX_W-1:0] issue_addr,
    input  logic [GRP_W-1:0]      issue_grp,
    input  logic [PAIR_W-1:0]     tag_rdata,
    input  logic [VAL_W-1:0]      val_rdata,
    output logic                  fail,
    output logic [FA_W-1:0]       fail_addr,
    output logic                  fail_half
);

    typedef struct packed {
        logic                  pend;
        logic                  inv;
        logic                  chk_val;
        logic [FULL_IDX_W-1:0] addr;
        logic [GRP_W-1:0]      grp;
        logic                  fail;
        logic [FA_W-1:0]       faddr;
        logic                  half;
    } cmp_t;

    cmp_t cmp_q, cmp_d;

    logic [PAIR_W-1:0] exp_tag;
    logic [VAL_W-1:0]  exp_val;
    logic [CMP_W-1:0]  diff;
    logic              hit;

    always_comb begin
        cmp_d         = cmp_q;
        cmp_d.pend    = issue_rd;
        cmp_d.inv     = issue_inv;
        cmp_d.chk_val = (issue_grp == '0);
        cmp_d.addr    = issue_addr;
        cmp_d.grp     = issue_grp;

        exp_tag = cmp_q.inv ? ~BG_TAG : BG_TAG;
        exp_val = cmp_q.inv ? ~BG_VAL : BG_VAL;
        diff    = {{CMP_PAD{1'b0}},
                   (cmp_q.chk_val ? (val_rdata ^ exp_val) : {VAL_W{1'b0}}),
                   (tag_rdata ^ exp_tag)};
        hit     = cmp_q.pend && (|diff);

        if (clear) begin
            cmp_d.fail  = 1'b0;
            cmp_d.faddr = '0;
            cmp_d.half  = 1'b0;
        end else if (hit) begin
            if (!cmp_q.fail) begin
                cmp_d.faddr = pack_fail_addr(cmp_q.grp, cmp_q.addr);
                cmp_d.half  = ~|diff[HALF_SPLIT-1:0];
            end
            cmp_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign fail      = cmp_q.fail;
    assign fail_addr = cmp_q.faddr;
    assign fail_half = cmp_q.half;

    // R8: the sticky flag survives until a new run clears it
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail);

    // R8: later miscompares leave the captured record untouched
    a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_half)));

endmodule

// File: rtl/tagval_bist.sv
module tagval_bist
    import tagval_bist_pkg::*;
#(
    parameter int                IDX_W  = 6,
    parameter logic [PAIR_W-1:0] BG_TAG = {PAIR_W/2{2'b01}},
    parameter logic [VAL_W-1:0]  BG_VAL = {VAL_W/2{2'b01}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FULL_IDX_W-1:0] scramble,
    input  logic [PAIR_W-1:0]     tag_rdata,
    input  logic [VAL_W-1:0]      val_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  fail,
    output logic [FA_W-1:0]       fail_addr,
    output logic                  fail_half,
    output logic                  tag_cs,
    output logic                  tag_we,
    output logic [GRP_W-1:0]      tag_grp,
    output logic [FULL_IDX_W-1:0] tag_addr,
    output logic [PAIR_W-1:0]     tag_wdata,
    output logic                  val_cs,
    output logic                  val_we,
    output logic [FULL_IDX_W-1:0] val_addr,
    output logic [VAL_W-1:0]      val_wdata
);

    logic [GRP_W-1:0]      step;
    logic [IDX_W-1:0]      idx;
    logic                  clear;
    logic                  req;
    logic                  we;
    logic                  inv;
    logic [FULL_IDX_W-1:0] addr;

    tagval_seq #(.IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .step  (step),
        .idx   (idx),
        .busy  (busy),
        .done  (done),
        .clear (clear),
        .req   (req),
        .we    (we),
        .inv   (inv)
    );

    tagval_addr #(.IDX_W(IDX_W)) u_addr (
        .idx      (idx),
        .scramble (scramble),
        .addr     (addr)
    );

    tagval_cmp #(.BG_TAG(BG_TAG), .BG_VAL(BG_VAL)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .issue_rd   (req && !we),
        .issue_inv  (inv),
        .issue_addr (addr),
        .issue_grp  (step),
        .tag_rdata  (tag_rdata),
        .val_rdata  (val_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_half  (fail_half)
    );

    always_comb begin
        tag_cs    = req;
        tag_we    = we;
        tag_grp   = step;
        tag_addr  = addr;
        tag_wdata = inv ? ~BG_TAG : BG_TAG;
        val_cs    = req && (step == '0);
        val_we    = we;
        val_addr  = addr;
        val_wdata = inv ? ~BG_VAL : BG_VAL;
    end

    // R1: way pairs are visited in rising order while accesses run back to back
    a_r1_grp_rising: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_cs && $past(tag_cs)) |-> (tag_grp >= $past(tag_grp)));

    // R3: once a later pair is under test the valid RAM stays deselected
    a_r3_valid_quiet_late: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (tag_grp != '0)) |=> !val_cs);

endmodule

// File: tb/tb_tagval_bist.sv
module tb_tagval_bist;
    import tagval_bist_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 3;
    localparam int DEPTH      = 1 << IDX_W;
    localparam int RUN_EDGES  = 16 * DEPTH + 1;
    localparam int N_VEC      = 9;

    typedef struct packed {
        logic       en;
        logic       sval;
        logic       on_val;
        logic [2:0] way;
        logic [2:0] idx;
        logic [5:0] bpos;
        logic [7:0] scr;
        logic       exp_half;
    } vec_t;

    // fault enable, stuck value, valid-RAM fault, way, index, bit, scramble, expected half
    localparam vec_t VECS [N_VEC] = '{
        '{1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 6'd0,  8'h3C, 1'b0},
        '{1'b1, 1'b1, 1'b0, 3'd0, 3'd2, 6'd10, 8'hA5, 1'b0},
        '{1'b1, 1'b0, 1'b0, 3'd1, 3'd7, 6'd8,  8'h5A, 1'b0},
        '{1'b1, 1'b1, 1'b0, 3'd1, 3'd0, 6'd9,  8'hFF, 1'b1},
        '{1'b1, 1'b0, 1'b0, 3'd4, 3'd3, 6'd22, 8'h00, 1'b0},
        '{1'b1, 1'b1, 1'b0, 3'd7, 3'd5, 6'd15, 8'h81, 1'b1},
        '{1'b1, 1'b0, 1'b1, 3'd0, 3'd6, 6'd15, 8'h42, 1'b1},
        '{1'b1, 1'b1, 1'b1, 3'd0, 3'd1, 6'd0,  8'h18, 1'b1},
        '{1'b1, 1'b0, 1'b0, 3'd3, 3'd4, 6'd1,  8'hC3, 1'b0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [FULL_IDX_W-1:0] scramble = '0;
    logic [PAIR_W-1:0]     tag_rdata = '0;
    logic [VAL_W-1:0]      val_rdata = '0;
    logic                  busy, done, fail, fail_half;
    logic [FA_W-1:0]       fail_addr;
    logic                  tag_cs, tag_we, val_cs, val_we;
    logic [GRP_W-1:0]      tag_grp;
    logic [FULL_IDX_W-1:0] tag_addr, val_addr;
    logic [PAIR_W-1:0]     tag_wdata;
    logic [VAL_W-1:0]      val_wdata;

    tagval_bist #(.IDX_W(IDX_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .scramble  (scramble),
        .tag_rdata (tag_rdata),
        .val_rdata (val_rdata),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_half (fail_half),
        .tag_cs    (tag_cs),
        .tag_we    (tag_we),
        .tag_grp   (tag_grp),
        .tag_addr  (tag_addr),
        .tag_wdata (tag_wdata),
        .val_cs    (val_cs),
        .val_we    (val_we),
        .val_addr  (val_addr),
        .val_wdata (val_wdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // up to two injected stuck-at faults
    logic       f_en   [2];
    logic       f_sval [2];
    logic       f_onv  [2];
    logic [2:0] f_way  [2];
    logic [2:0] f_idx  [2];
    logic [5:0] f_bit  [2];

    logic [22:0] tmem [8][DEPTH];
    logic [15:0] vmem [DEPTH];

    // RAM model: one-cycle registered read, two ways per tag word
    always @(posedge clk) begin
        logic [22:0] lo, hi;
        logic [15:0] vw;
        logic [IDX_W-1:0] ti, vi;
        ti = tag_addr[IDX_W-1:0];
        vi = val_addr[IDX_W-1:0];
        if (tag_cs) begin
            if (tag_we) begin
                tmem[{tag_grp, 1'b0}][ti] = tag_wdata[22:0];
                tmem[{tag_grp, 1'b1}][ti] = tag_wdata[45:23];
            end else begin
                lo = tmem[{tag_grp, 1'b0}][ti];
                hi = tmem[{tag_grp, 1'b1}][ti];
                for (int k = 0; k < 2; k++) begin
                    if (f_en[k] && !f_onv[k] && f_idx[k] == ti) begin
                        if (f_way[k] == {tag_grp, 1'b0}) lo[f_bit[k]] = f_sval[k];
                        if (f_way[k] == {tag_grp, 1'b1}) hi[f_bit[k]] = f_sval[k];
                    end
                end
                tag_rdata <= {hi, lo};
            end
        end
        if (val_cs) begin
            if (val_we) begin
                vmem[vi] = val_wdata;
            end else begin
                vw = vmem[vi];
                for (int k = 0; k < 2; k++) begin
                    if (f_en[k] && f_onv[k] && f_idx[k] == vi) vw[f_bit[k]] = f_sval[k];
                end
                val_rdata <= vw;
            end
        end
    end

    // monitor: cumulative counters sampled on the falling edge
    int tcs_tot = 0, vcs_tot = 0, done_tot = 0, scr_bad = 0, vgrp_bad = 0, grp_bad = 0;
    logic [GRP_W-1:0] last_grp = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tag_cs) tcs_tot++;
            if (val_cs) vcs_tot++;
            if (done) done_tot++;
            if (tag_cs && tag_addr[10:IDX_W] != scramble[10:IDX_W]) scr_bad++;
            if (val_cs && val_addr[10:IDX_W] != scramble[10:IDX_W]) scr_bad++;
            if (val_cs && tag_grp != '0) vgrp_bad++;
            if (tag_cs && busy && tag_grp < last_grp) grp_bad++;
            last_grp = busy ? tag_grp : '0;
        end
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer than 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int lat, d_tcs, d_vcs, d_done, d_scr, d_vgrp, d_grp;

    task automatic run_bist(input logic [7:0] scr, input logic mid_start);
        int b_tcs, b_vcs, b_done, b_scr, b_vgrp, b_grp;
        @(negedge clk);
        scramble = {scr, 3'b000};
        start = 1'b1;
        @(posedge clk);
        b_tcs = tcs_tot; b_vcs = vcs_tot; b_done = done_tot;
        b_scr = scr_bad; b_vgrp = vgrp_bad; b_grp = grp_bad;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = mid_start && (lat == 20);
        end while (!done && lat < 400);
        start = 1'b0;
        @(posedge clk);
        d_tcs = tcs_tot - b_tcs; d_vcs = vcs_tot - b_vcs; d_done = done_tot - b_done;
        d_scr = scr_bad - b_scr; d_vgrp = vgrp_bad - b_vgrp; d_grp = grp_bad - b_grp;
        @(negedge clk);
    endtask

    task automatic run_checks(input string tag);
        chk("R9",  {tag, " done latency"}, 64'(lat), 64'(RUN_EDGES));
        chk("R9",  {tag, " done pulses"}, 64'(d_done), 64'd1);
        chk("R7",  {tag, " tag accesses"}, 64'(d_tcs), 64'(16 * DEPTH));
        chk("R3",  {tag, " valid accesses"}, 64'(d_vcs), 64'(4 * DEPTH));
        chk("R3",  {tag, " valid select outside step 0"}, 64'(d_vgrp), 64'd0);
        chk("R5",  {tag, " upper address bits"}, 64'(d_scr), 64'd0);
        chk("R1",  {tag, " group order"}, 64'(d_grp), 64'd0);
        chk("R9",  {tag, " idle after done"}, 64'(busy), 64'd0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            f_en[k] = 1'b0; f_sval[k] = 1'b0; f_onv[k] = 1'b0;
            f_way[k] = '0; f_idx[k] = '0; f_bit[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "busy in reset", 64'(busy), 64'd0);
        chk("R11", "done in reset", 64'(done), 64'd0);
        chk("R11", "fail in reset", 64'(fail), 64'd0);
        chk("R11", "fail_addr in reset", 64'(fail_addr), 64'd0);
        chk("R11", "fail_half in reset", 64'(fail_half), 64'd0);
        chk("R11", "tag_cs in reset", 64'(tag_cs), 64'd0);
        chk("R11", "val_cs in reset", 64'(val_cs), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of single-fault runs: R2 packing, R4 address, R6 half, R10 alignment
        for (int v = 0; v < N_VEC; v++) begin
            vec_t  cv;
            string tg;
            logic [1:0]      eg;
            logic [FA_W-1:0] ea;
            cv = VECS[v];
            f_en[0] = cv.en; f_sval[0] = cv.sval; f_onv[0] = cv.on_val;
            f_way[0] = cv.way; f_idx[0] = cv.idx; f_bit[0] = cv.bpos;
            f_en[1] = 1'b0;
            tg = $sformatf("vec%0d", v);
            run_bist(cv.scr, 1'b0);
            run_checks(tg);
            chk("R8", {tg, " fail flag"}, 64'(fail), 64'(cv.en));
            if (cv.en) begin
                eg = cv.on_val ? 2'd0 : cv.way[2:1];
                ea = {eg, 4'b0000, cv.scr, cv.idx};
                chk("R4 R10 R2", {tg, " fail_addr"}, 64'(fail_addr), 64'(ea));
                chk("R6", {tg, " fail_half"}, 64'(fail_half), 64'(cv.exp_half));
            end
        end

        // R8: two faults, the earlier-tested pair wins, later one is ignored
        f_en[0] = 1'b1; f_sval[0] = 1'b0; f_onv[0] = 1'b0; f_way[0] = 3'd6; f_idx[0] = 3'd1; f_bit[0] = 6'd3;
        f_en[1] = 1'b1; f_sval[1] = 1'b1; f_onv[1] = 1'b0; f_way[1] = 3'd2; f_idx[1] = 3'd5; f_bit[1] = 6'd4;
        run_bist(8'h77, 1'b0);
        chk("R8", "two faults fail flag", 64'(fail), 64'd1);
        chk("R8", "two faults first address kept", 64'(fail_addr), 64'({2'd1, 4'b0000, 8'h77, 3'd5}));
        chk("R8", "two faults first half kept", 64'(fail_half), 64'd0);

        // R12: a clean run clears the previous verdict
        f_en[0] = 1'b0; f_en[1] = 1'b0;
        run_bist(8'h12, 1'b0);
        chk("R12", "fail cleared", 64'(fail), 64'd0);
        chk("R12", "fail_addr cleared", 64'(fail_addr), 64'd0);
        chk("R12", "fail_half cleared", 64'(fail_half), 64'd0);

        // R9: start pulse mid-run is ignored
        run_bist(8'hE7, 1'b1);
        run_checks("midstart");
        chk("R9", "midstart no fail", 64'(fail), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule